// File: doc/BRIEF.md
# Outstanding Memory Request Tracker

This block sits between a processor memory port and a cache controller and keeps a record of every cache-line request that has been sent downstream but not yet answered. Each incoming request is sorted into a read class or a write class by its kind code and filed under its line address. The address of a line is the request address with the low offset bits cleared. The tracker answers every request in the same cycle with one of three outcomes: issued, refused because another request to that line is already pending, or refused because the tracker is full. An issued request is forwarded on the issue port one cycle later, together with the hit latency that the controller should apply.

The controller later returns a response that names the line and says whether it completes a read-class or a write-class entry. A matching response frees that entry and reports the round-trip latency in cycles. A response that matches nothing raises an error pulse. Four saturating counters record which kind of alias caused each refusal. A periodic watchdog sets a sticky deadlock flag if any entry has been pending for the threshold number of cycles or longer.

Top module: `outstanding_req_tracker`

## Requirements
- R1: While the occupancy equals MAX_OUT, every request gets status 2 (full). This is decided before classification, so no alias counter changes and nothing is issued.
- R2: Kind codes 0 (load) and 1 (instruction fetch) are read-class. Codes 2 to 8 are write-class: store, read-for-modify, locked read half, locked write half, load-linked, store-conditional and flush.
- R3: A write-class request whose line is pending in the read table is refused with status 1 and increments the store-on-load counter. If the line is instead pending in the write table, the request is refused with status 1 and increments the store-on-store counter.
- R4: A read-class request whose line is pending in the write table is refused with status 1 and increments the load-on-store counter. If the line is instead pending in the read table, the request is refused with status 1 and increments the load-on-load counter.
- R5: An accepted request gets status 0. In the next cycle, iss_valid is 1, iss_addr holds the line address, iss_kind holds the kind, and occupancy has grown by one.
- R6: iss_lat equals ICACHE_LAT for kind 1 and DCACHE_LAT for every other kind.
- R7: A response that matches an entry in the table selected by rsp_wr (1 selects the write table) frees that entry. In the next cycle done_valid is 1 and done_lat equals the response cycle minus the request cycle.
- R8: A response with no matching entry in the selected table pulses rsp_err in the next cycle and leaves the occupancy unchanged.
- R9: While any entry is outstanding, all entries are checked once every WD_THRESH cycles. If any entry's age has reached WD_THRESH, deadlock is set and stays set until reset. Entries that complete in well under WD_THRESH cycles never set it.
- R10: Occupancy always equals the number of valid read entries plus the number of valid write entries, and is 0 after reset.
- R11: Each alias counter saturates at 2^CNT_W-1.
- R12: The low LINE_OFF address bits are ignored when matching both requests and responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Request byte address |
| req_kind | input | 4 | Request kind code |
| req_status | output | 2 | 0 issued, 1 aliased, 2 full (valid with req_valid) |
| iss_valid | output | 1 | Downstream issue strobe |
| iss_addr | output | ADDR_W | Issued line address |
| iss_kind | output | 4 | Issued kind code |
| iss_lat | output | LAT_W | Hit latency for the issued request |
| rsp_valid | input | 1 | Response present |
| rsp_wr | input | 1 | Response completes a write-class entry |
| rsp_addr | input | ADDR_W | Response address |
| done_valid | output | 1 | Entry completed |
| done_lat | output | CYC_W | Round-trip latency in cycles |
| rsp_err | output | 1 | Response matched no entry |
| occupancy | output | clog2(MAX_OUT+1) | Outstanding entry count |
| deadlock | output | 1 | Sticky stuck-request flag |
| cnt_st_ld | output | CNT_W | Store-on-load alias count |
| cnt_st_st | output | CNT_W | Store-on-store alias count |
| cnt_ld_ld | output | CNT_W | Load-on-load alias count |
| cnt_ld_st | output | CNT_W | Load-on-store alias count |

## Verification
A lost or duplicated table entry appears at the ports within one request: either a second request to the same line is accepted when it should be refused as aliased, or its response raises rsp_err instead of done_valid. A stored issue time that is wrong shows up as a wrong done_lat in the cycle after the response. A miscounted occupancy shows up either as a premature full status or as a missing full refusal once MAX_OUT requests are pending. A wrong age or a wrong watchdog period shows up within two watchdog periods, as a deadlock flag that rises too early or never rises.

// File: rtl/outstanding_req_tracker.sv
module outstanding_req_tracker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_OFF   = 6,
  parameter int MAX_OUT    = 4,
  parameter int WD_THRESH  = 64,
  parameter int ICACHE_LAT = 1,
  parameter int DCACHE_LAT = 2,
  parameter int LAT_W      = 4,
  parameter int CYC_W      = 16,
  parameter int CNT_W      = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  input  logic [ADDR_W-1:0]              req_addr,
  input  logic [3:0]                     req_kind,
  output logic [1:0]                     req_status,
  output logic                           iss_valid,
  output logic [ADDR_W-1:0]              iss_addr,
  output logic [3:0]                     iss_kind,
  output logic [LAT_W-1:0]               iss_lat,
  input  logic                           rsp_valid,
  input  logic                           rsp_wr,
  input  logic [ADDR_W-1:0]              rsp_addr,
  output logic                           done_valid,
  output logic [CYC_W-1:0]               done_lat,
  output logic                           rsp_err,
  output logic [$clog2(MAX_OUT+1)-1:0]   occupancy,
  output logic                           deadlock,
  output logic [CNT_W-1:0]               cnt_st_ld,
  output logic [CNT_W-1:0]               cnt_st_st,
  output logic [CNT_W-1:0]               cnt_ld_ld,
  output logic [CNT_W-1:0]               cnt_ld_st
);
  localparam int OCC_W = $clog2(MAX_OUT+1);
  localparam logic [ADDR_W-1:0] LMASK = {ADDR_W{1'b1}} << LINE_OFF;

  logic [MAX_OUT-1:0] rd_v, wr_v, rd_hit, wr_hit, rd_rhit, wr_rhit, rd_set, wr_set;
  logic [ADDR_W-1:0]  rd_line [MAX_OUT];
  logic [ADDR_W-1:0]  wr_line [MAX_OUT];
  logic [CYC_W-1:0]   rd_t [MAX_OUT];
  logic [CYC_W-1:0]   wr_t [MAX_OUT];
  logic [CYC_W-1:0]   now, wd_cnt, hit_t;
  logic               stale;

  wire [ADDR_W-1:0] req_line = req_addr & LMASK;
  wire [ADDR_W-1:0] rsp_line = rsp_addr & LMASK;
  wire req_is_wr = (req_kind != 4'd0) && (req_kind != 4'd1);
  wire is_full   = occupancy >= OCC_W'(MAX_OUT);
  wire in_rd     = |rd_hit;
  wire in_wr     = |wr_hit;
  wire alias_hit = in_rd | in_wr;
  wire accept    = req_valid && !is_full && !alias_hit;
  wire rsp_hit   = rsp_wr ? |wr_rhit : |rd_rhit;
  wire rsp_free  = rsp_valid && rsp_hit;
  wire chk_now   = (occupancy != '0) && (wd_cnt == CYC_W'(WD_THRESH - 1));

  wire ev_st_ld = req_valid && !is_full && req_is_wr && in_rd;
  wire ev_st_st = req_valid && !is_full && req_is_wr && !in_rd && in_wr;
  wire ev_ld_st = req_valid && !is_full && !req_is_wr && in_wr;
  wire ev_ld_ld = req_valid && !is_full && !req_is_wr && !in_wr && in_rd;

  assign req_status = !req_valid ? 2'd0 : is_full ? 2'd2 : alias_hit ? 2'd1 : 2'd0;
  assign iss_lat    = (iss_kind == 4'd1) ? LAT_W'(ICACHE_LAT) : LAT_W'(DCACHE_LAT);

  for (genvar g = 0; g < MAX_OUT; g++) begin : g_cmp
    assign rd_hit[g]  = rd_v[g] && (rd_line[g] == req_line);
    assign wr_hit[g]  = wr_v[g] && (wr_line[g] == req_line);
    assign rd_rhit[g] = rd_v[g] && (rd_line[g] == rsp_line);
    assign wr_rhit[g] = wr_v[g] && (wr_line[g] == rsp_line);
  end

  always_comb begin
    rd_set = '0;
    wr_set = '0;
    hit_t  = '0;
    stale  = 1'b0;
    for (int i = MAX_OUT-1; i >= 0; i--) begin
      if (!rd_v[i]) rd_set = MAX_OUT'(1) << i;
      if (!wr_v[i]) wr_set = MAX_OUT'(1) << i;
    end
    if (!accept || req_is_wr)  rd_set = '0;
    if (!accept || !req_is_wr) wr_set = '0;
    for (int i = 0; i < MAX_OUT; i++) begin
      if (rsp_wr ? wr_rhit[i] : rd_rhit[i]) hit_t = hit_t | (rsp_wr ? wr_t[i] : rd_t[i]);
      if (rd_v[i] && (now - rd_t[i]) >= CYC_W'(WD_THRESH)) stale = 1'b1;
      if (wr_v[i] && (now - wr_t[i]) >= CYC_W'(WD_THRESH)) stale = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < MAX_OUT; i++) begin
      if (rd_set[i]) begin rd_line[i] <= req_line; rd_t[i] <= now; end
      if (wr_set[i]) begin wr_line[i] <= req_line; wr_t[i] <= now; end
    end
    iss_addr <= req_line;
    iss_kind <= req_kind;
    done_lat <= now - hit_t;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_v <= '0; wr_v <= '0; occupancy <= '0; now <= '0; wd_cnt <= '0;
      iss_valid <= 1'b0; done_valid <= 1'b0; rsp_err <= 1'b0; deadlock <= 1'b0;
      cnt_st_ld <= '0; cnt_st_st <= '0; cnt_ld_ld <= '0; cnt_ld_st <= '0;
    end else begin
      rd_v <= (rd_v & ~((rsp_free && !rsp_wr) ? rd_rhit : '0)) | rd_set;
      wr_v <= (wr_v & ~((rsp_free &&  rsp_wr) ? wr_rhit : '0)) | wr_set;
      if (accept && !rsp_free)      occupancy <= occupancy + 1'b1;
      else if (!accept && rsp_free) occupancy <= occupancy - 1'b1;
      now        <= now + 1'b1;
      iss_valid  <= accept;
      done_valid <= rsp_free;
      rsp_err    <= rsp_valid && !rsp_hit;
      if (occupancy == '0 || chk_now) wd_cnt <= '0;
      else                            wd_cnt <= wd_cnt + 1'b1;
      if (chk_now && stale) deadlock <= 1'b1;
      if (ev_st_ld && cnt_st_ld != '1) cnt_st_ld <= cnt_st_ld + 1'b1;
      if (ev_st_st && cnt_st_st != '1) cnt_st_st <= cnt_st_st + 1'b1;
      if (ev_ld_ld && cnt_ld_ld != '1) cnt_ld_ld <= cnt_ld_ld + 1'b1;
      if (ev_ld_st && cnt_ld_st != '1) cnt_ld_st <= cnt_ld_st + 1'b1;
    end
  end

  // R10: count tracks the two tables
  a_r10_occ_matches: assert property (@(posedge clk) disable iff (!rst_n)
    32'(occupancy) == $countones(rd_v) + $countones(wr_v));
  // R1: never above the limit
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= OCC_W'(MAX_OUT));
  // R1: full refusal issues nothing
  a_r1_full_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_status == 2'd2) |=> !iss_valid);
  // R5: acceptance alone grows the count by one
  a_r5_accept_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_status == 2'd0 && !rsp_valid) |=> occupancy == $past(occupancy) + 1'b1);
  // R8: an unmatched response frees nothing
  a_r8_err_keeps_occ: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit && !(req_valid && req_status == 2'd0)) |=> (rsp_err && $stable(occupancy)));
  // R7: completion and error never coincide
  a_r7_done_or_err: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_valid && rsp_err));
  // R9: deadlock flag is sticky
  a_r9_deadlock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    deadlock |=> deadlock);
  // R11: saturated counter stays saturated
  a_r11_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_ld_ld == '1) |=> (cnt_ld_ld == '1));
endmodule

// File: tb/outstanding_req_tracker_test.sv
module outstanding_req_tracker_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, rsp_valid = 1'b0, rsp_wr = 1'b0;
  logic [31:0] req_addr = '0, rsp_addr = '0;
  logic [3:0]  req_kind = '0;
  logic [1:0]  req_status;
  logic        iss_valid, done_valid, rsp_err, deadlock;
  logic [31:0] iss_addr;
  logic [3:0]  iss_kind, iss_lat;
  logic [15:0] done_lat;
  logic [2:0]  occupancy;
  logic [1:0]  cnt_st_ld, cnt_st_st, cnt_ld_ld, cnt_ld_st;

  outstanding_req_tracker #(.ADDR_W(32), .LINE_OFF(6), .MAX_OUT(4), .WD_THRESH(16),
    .ICACHE_LAT(3), .DCACHE_LAT(5), .LAT_W(4), .CYC_W(16), .CNT_W(2)) uut (.*);

  always #5 clk = ~clk;

  int cyc = 0, nchk = 0, nfail = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [1:0] st; int t0, t1;
  logic s_iv, s_dv, s_er; logic [31:0] s_ia; logic [3:0] s_ik, s_il; logic [15:0] s_dl;

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    nchk++;
    if (!ok) begin nfail++; $display("FAIL %s actual=%0d expected=%0d", r, act, exp); end
  endtask

  task automatic send(input logic [31:0] a, input logic [3:0] k);
    @(negedge clk); req_valid = 1; req_addr = a; req_kind = k; #1; st = req_status; t0 = cyc;
    @(negedge clk); s_iv = iss_valid; s_ia = iss_addr; s_ik = iss_kind; s_il = iss_lat; req_valid = 0;
  endtask

  task automatic resp(input logic w, input logic [31:0] a);
    @(negedge clk); rsp_valid = 1; rsp_wr = w; rsp_addr = a; t1 = cyc;
    @(negedge clk); s_dv = done_valid; s_dl = done_lat; s_er = rsp_err; rsp_valid = 0;
  endtask

  task automatic t_reset();
    chk(occupancy == 0, "R10 reset occupancy", occupancy, 0);
    chk(!deadlock && !rsp_err && !done_valid && !iss_valid, "R9 reset flags", deadlock, 0);
    chk(cnt_ld_ld == 0 && cnt_st_st == 0, "R11 reset counters", cnt_ld_ld, 0);
  endtask

  task automatic t_basic();
    int ta;
    send(32'h1010, 4'd0); ta = t0;
    chk(st == 0, "R5 load status", st, 0);
    chk(s_iv && s_ia == 32'h1000 && s_ik == 0, "R5 issue line", s_ia, 32'h1000);
    chk(s_il == 5, "R6 data latency", s_il, 5);
    chk(occupancy == 1, "R5 occupancy up", occupancy, 1);
    send(32'h2044, 4'd1);
    chk(st == 0 && s_il == 3, "R6 fetch latency", s_il, 3);
    repeat (3) @(negedge clk);
    resp(1'b0, 32'h1000);
    chk(s_dv && !s_er, "R7 read done", s_dv, 1);
    chk(s_dl == 16'(t1 - ta), "R7 latency", s_dl, t1 - ta);
    resp(1'b0, 32'h2040);
    chk(s_dv && occupancy == 0, "R10 drained", occupancy, 0);
  endtask

  task automatic t_alias();
    send(32'h3000, 4'd2);
    send(32'h3008, 4'd0);
    chk(st == 1 && !s_iv, "R4 load on store", st, 1);
    send(32'h3014, 4'd2);
    chk(st == 1, "R3 store on store", st, 1);
    resp(1'b1, 32'h3000);
    send(32'h4000, 4'd0);
    send(32'h4004, 4'd7);
    chk(st == 1, "R3 store on load", st, 1);
    send(32'h4030, 4'd1);
    chk(st == 1, "R4 load on load", st, 1);
    chk(cnt_st_ld == 1 && cnt_st_st == 1 && cnt_ld_ld == 1 && cnt_ld_st == 1,
        "R3 R4 alias counters", {cnt_st_ld, cnt_st_st, cnt_ld_ld, cnt_ld_st}, 8'h55);
    resp(1'b0, 32'h4000);
    chk(occupancy == 0, "R10 alias drained", occupancy, 0);
  endtask

  task automatic t_full();
    for (int i = 0; i < 4; i++) send(32'h5000 + 32'(i) * 32'h40, 4'd0);
    chk(occupancy == 4, "R1 filled", occupancy, 4);
    send(32'h5000, 4'd0);
    chk(st == 2 && !s_iv, "R1 full before alias", st, 2);
    chk(cnt_ld_ld == 1, "R1 no alias count when full", cnt_ld_ld, 1);
    send(32'h9000, 4'd2);
    chk(st == 2 && occupancy == 4, "R1 full store", st, 2);
    for (int i = 0; i < 4; i++) resp(1'b0, 32'h5000 + 32'(i) * 32'h40);
    chk(occupancy == 0, "R1 drained", occupancy, 0);
  endtask

  task automatic t_sat();
    send(32'h6000, 4'd0);
    for (int i = 0; i < 4; i++) send(32'h6000, 4'd0);
    chk(cnt_ld_ld == 3, "R11 saturation", cnt_ld_ld, 3);
    resp(1'b0, 32'h6000);
  endtask

  task automatic t_class();
    for (int k = 2; k <= 8; k++) begin
      send(32'h7000, 4'(k));
      chk(st == 0 && s_ik == 4'(k), "R2 write kind accepted", st, 0);
      send(32'h7000, 4'd0);
      chk(st == 1, "R2 write kind aliases load", st, 1);
      resp(1'b1, 32'h7000);
      chk(s_dv && !s_er, "R2 write-class completion", s_dv, 1);
    end
  endtask

  task automatic t_unmatched();
    resp(1'b0, 32'h1000);
    chk(s_er && !s_dv, "R8 stray response", s_er, 1);
    send(32'h8000, 4'd8);
    resp(1'b0, 32'h8000);
    chk(s_er && occupancy == 1, "R8 wrong table", occupancy, 1);
    resp(1'b1, 32'h8028);
    chk(s_dv && !s_er && occupancy == 0, "R12 offset ignored", s_dv, 1);
  endtask

  task automatic t_watchdog();
    send(32'hA000, 4'd0);
    repeat (8) @(negedge clk);
    resp(1'b0, 32'hA000);
    repeat (30) @(negedge clk);
    chk(!deadlock, "R9 short entry no deadlock", deadlock, 0);
    send(32'hA000, 4'd0);
    repeat (40) @(negedge clk);
    chk(deadlock, "R9 stuck entry flagged", deadlock, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_alias();
    t_full();
    t_sat();
    t_class();
    t_unmatched();
    t_watchdog();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #2000000;
    nchk++; nfail++;
    $display("FAIL watchdog timeout actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule